// File: doc/BRIEF.md
# PC Card Byte-Lane Access Decoder

This block sits on the card side of a removable storage card's host connector. It watches the host strobes (register select, the two chip enables, address bit 0, output and write enables, and the I/O read and write strobes) and decides which internal region a cycle is aimed at. The three regions are attribute memory, the task file reached through memory cycles, and the task file reached through I/O cycles. It then routes bytes between the two 8-bit data lanes and the internal register array, and reports through per-lane enables which lanes the card must drive. A lane that is not enabled must float at the pins.

At power-on reset the block samples the output-enable strobe. If that strobe is held low, the block takes on a disk-drive personality. In that mode only the I/O strobes reach the task file, attribute memory is shut off, the data register is 16 bits wide until a feature command narrows it, and a secondary chip-enable window exposes alternate status and device control. Reads are combinational from the strobes. Writes are captured while the strobe is low and committed on the clock edge that first sees the strobe deasserted.

Top module: `pcc_lane_decoder`

## Requirements
- R1: With both chip enables high, neither lane is enabled and a write strobe changes no register.
- R2: With the first chip enable low and the second high, only the low lane is used, and address bit 0 selects the even (0) or odd (1) byte of the pair.
- R3: With both chip enables low, both lanes are used: the even byte on bits 7:0 and the odd byte on bits 15:8.
- R4: With the first chip enable high and the second low, only the high lane carries the odd byte, and the low lane stays disabled.
- R5: With register select low, output and write enable cycles reach attribute memory (256 byte addresses, storage at even addresses only). Odd attribute addresses and the high lane of an attribute read return 0xFF, and odd attribute writes are dropped.
- R6: Attribute addresses below 128 form a read-only table whose byte at address 2i resets to (37*i+5) mod 256. Writes there have no effect. Even addresses from 128 up are writable and reset to 0.
- R7: Outside disk mode, the task file is reached by I/O strobes with register select low, or by output and write enable with register select high. The offset is address bits 2:0. The high byte of offset pair 0 is a separate data-high register, so offset 1 on the low lane is the feature/error byte.
- R8: If the output enable is low on the last reset cycle, disk mode is entered and held. Register select, output enable and write enable are then ignored, and only the I/O strobes with chip enables (low, high) reach the task file. Chip enables both low select nothing.
- R9: In disk mode, offset 0 is a 16-bit data word. Writing 0x01 to offset 1 and then 0xEF to offset 7 makes it 8-bit (low lane only). The same command with 0x81 at offset 1 restores 16-bit.
- R10: In disk mode, with chip enables (high, low) and offset 6, a read returns the status byte at offset 7 on the low lane, and a write sets the device-control output without touching task register 6.
- R11: Lane enables and read data follow the strobes in the same cycle. A write becomes visible after the first clock edge that samples its strobe high again.
- R12: After reset, outside disk mode, task register 7 (status) reads 0x50, all other task registers read 0, and the disk-mode output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_n | input | 1 | Register/attribute space select, active low |
| ce1_n | input | 1 | Low byte chip enable, active low |
| ce2_n | input | 1 | High byte chip enable, active low |
| addr | input | ADDR_W | Byte address; bit 0 picks even/odd |
| oe_n | input | 1 | Memory read strobe; power-on mode strap |
| we_n | input | 1 | Memory write strobe |
| iord_n | input | 1 | I/O read strobe |
| iowr_n | input | 1 | I/O write strobe |
| wdata | input | 16 | Host write data, both lanes |
| rdata | output | 16 | Read data, zero on disabled lanes |
| lo_oe | output | 1 | Drive bits 7:0 toward the host |
| hi_oe | output | 1 | Drive bits 15:8 toward the host |
| ide_mode | output | 1 | Disk personality latched at reset |
| ctl_q | output | 8 | Device-control byte written in disk mode |

## Verification
Every cycle, the checker confirms that standby and invalid chip-enable combinations leave both lanes off, that the odd-only and byte widths never enable the wrong lane, and that attribute reads put 0xFF on the high lane. It also confirms that the latched personality never changes after reset and that device control only moves right after an I/O write strobe is released. The bench scenarios are what show the data content: read-only table protection, task-file byte placement across the three widths, the data-high register at pair 0, the narrowing and restoring of the data port by the feature command, and the exact cycle in which a committed write becomes readable.

// File: rtl/pcc_pkg.sv
// Shared types and constants for the byte-lane access decoder.
// Assumes: a single clock domain; the strobes are already synchronous to clk.
package pcc_pkg;

    // Internal region reached by the current host cycle
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_ATTR = 2'd1,
        RGN_TASK = 2'd2,
        RGN_ALT  = 2'd3
    } region_e;

    // Transfer width selected by the two chip enables
    typedef enum logic [1:0] {
        WID_IDLE = 2'd0,
        WID_BYTE = 2'd1,
        WID_WORD = 2'd2,
        WID_ODD  = 2'd3
    } width_e;

    localparam logic [7:0] CMD_SET_FEATURE = 8'hEF;
    localparam logic [7:0] FEAT_BUS8_ON    = 8'h01;
    localparam logic [7:0] FEAT_BUS8_OFF   = 8'h81;
    localparam logic [7:0] STATUS_AT_RESET = 8'h50;
    localparam logic [7:0] INVALID_BYTE    = 8'hFF;

    // Reset content of the read-only attribute table, entry idx
    function automatic logic [7:0] table_seed(input int unsigned idx);
        return 8'((idx * 37 + 5) % 256);
    endfunction

endpackage

// File: rtl/pcc_mode_latch.sv
// Personality strap: while reset is held, follows the inverted output-enable
// strobe; after reset it keeps the value seen on the last reset cycle.
// Assumes: reset is synchronous and lasts at least one clock.
module pcc_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic ide_mode
);

    // Sample the strap on every reset cycle, hold it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ide_mode <= ~oe_n;
        end
    end

endmodule

// File: rtl/pcc_access_decode.sv
// Combinational cycle decoder: turns the strobes into a region, read and
// write activity, and the byte address carried by each lane.
// Assumes: strobes are glitch-free at the clock; in disk mode only the low
// TF_AW address bits are meaningful.
module pcc_access_decode
    import pcc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TF_AW  = 3
) (
    input  logic              ide_mode,
    input  logic              bus8,
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    output region_e           region,
    output logic              rd_act,
    output logic              wr_act,
    output logic              lo_act,
    output logic              hi_act,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr
);

    localparam logic [TF_AW-1:0] ALT_OFFSET = TF_AW'(6);

    width_e            width;
    logic              attr_cyc;
    logic              mem_cyc;
    logic              io_cyc;
    logic [ADDR_W-1:0] even_addr;
    logic [ADDR_W-1:0] odd_addr;
    logic [TF_AW-1:0]  tf_off;

    // Width from the chip-enable pair
    always_comb begin
        unique case ({ce2_n, ce1_n})
            2'b10:   width = WID_BYTE;
            2'b00:   width = WID_WORD;
            2'b01:   width = WID_ODD;
            default: width = WID_IDLE;
        endcase
    end

    assign even_addr = {addr[ADDR_W-1:1], 1'b0};
    assign odd_addr  = {addr[ADDR_W-1:1], 1'b1};
    assign tf_off    = addr[TF_AW-1:0];

    // Cycle classification for the card personalities
    always_comb begin
        attr_cyc = !reg_n && (!oe_n || !we_n);
        mem_cyc  = reg_n && (!oe_n || !we_n);
        io_cyc   = !reg_n && !attr_cyc && (!iord_n || !iowr_n);
    end

    // Region, activity and lane addressing
    always_comb begin
        region  = RGN_NONE;
        rd_act  = 1'b0;
        wr_act  = 1'b0;
        lo_act  = 1'b0;
        hi_act  = 1'b0;
        lo_addr = '0;
        hi_addr = '0;
        if (!ide_mode) begin
            if (attr_cyc || mem_cyc) begin
                rd_act = !oe_n;
                wr_act = !we_n;
            end else if (io_cyc) begin
                rd_act = !iord_n;
                wr_act = !iowr_n;
            end
            if (width != WID_IDLE && (attr_cyc || mem_cyc || io_cyc)) begin
                region = attr_cyc ? RGN_ATTR : RGN_TASK;
            end
            unique case (width)
                WID_BYTE: begin
                    lo_act  = 1'b1;
                    lo_addr = addr;
                end
                WID_WORD: begin
                    lo_act  = 1'b1;
                    hi_act  = 1'b1;
                    lo_addr = even_addr;
                    hi_addr = odd_addr;
                end
                WID_ODD: begin
                    hi_act  = 1'b1;
                    hi_addr = odd_addr;
                end
                default: ;
            endcase
        end else begin
            rd_act = !iord_n;
            wr_act = !iowr_n;
            if (width == WID_BYTE && (rd_act || wr_act)) begin
                region  = RGN_TASK;
                lo_act  = 1'b1;
                lo_addr = ADDR_W'(tf_off);
                if (tf_off == '0 && !bus8) begin
                    hi_act  = 1'b1;
                    hi_addr = ADDR_W'(1);
                end
            end else if (width == WID_ODD && tf_off == ALT_OFFSET && (rd_act || wr_act)) begin
                region = RGN_ALT;
                lo_act = 1'b1;
            end
        end
        if (region == RGN_NONE) begin
            rd_act = 1'b0;
            wr_act = 1'b0;
            lo_act = 1'b0;
            hi_act = 1'b0;
        end
    end

endmodule

// File: rtl/pcc_regfile.sv
// Internal register array: attribute bytes (even addresses only, with a
// read-only table at the bottom), the task file, a data-high byte and the
// device-control byte. Reads are combinational; writes are captured while
// the strobe is active and committed when it is released.
// Assumes: the decoder has already gated activity by region.
module pcc_regfile
    import pcc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int TF_AW     = 3,
    parameter int CIS_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  region_e           region,
    input  logic              wr_act,
    input  logic              lo_act,
    input  logic              hi_act,
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [15:0]       wdata,
    output logic [7:0]        rd_lo,
    output logic [7:0]        rd_hi,
    output logic              bus8,
    output logic [7:0]        ctl_q
);

    localparam int ATTR_DEPTH = (2 ** ADDR_W) / 2;
    localparam int TF_DEPTH   = 2 ** TF_AW;
    localparam int ROM_WORDS  = CIS_BYTES / 2;
    localparam logic [TF_AW-1:0] OFF_FEAT = TF_AW'(1);
    localparam logic [TF_AW-1:0] OFF_CMD  = TF_AW'(TF_DEPTH - 1);

    logic [7:0] attr_mem [ATTR_DEPTH];
    logic [7:0] tf_mem   [TF_DEPTH];
    logic [7:0] data_hi;

    logic              pend;
    region_e           c_region;
    logic              c_lo;
    logic              c_hi;
    logic [ADDR_W-1:0] c_lo_addr;
    logic [ADDR_W-1:0] c_hi_addr;
    logic [15:0]       c_data;
    logic              commit;
    logic [TF_AW-1:0]  c_lo_off;
    logic [TF_AW-1:0]  c_hi_off;

    assign commit   = pend && !wr_act;
    assign c_lo_off = c_lo_addr[TF_AW-1:0];
    assign c_hi_off = c_hi_addr[TF_AW-1:0];

    // Capture the write cycle while its strobe is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            c_region  <= RGN_NONE;
            c_lo      <= 1'b0;
            c_hi      <= 1'b0;
            c_lo_addr <= '0;
            c_hi_addr <= '0;
            c_data    <= '0;
        end else if (wr_act) begin
            pend      <= 1'b1;
            c_region  <= region;
            c_lo      <= lo_act;
            c_hi      <= hi_act;
            c_lo_addr <= lo_addr;
            c_hi_addr <= hi_addr;
            c_data    <= wdata;
        end else begin
            pend <= 1'b0;
        end
    end

    // Commit a captured write into the storage on strobe release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ATTR_DEPTH; i++) begin
                attr_mem[i] <= (i < ROM_WORDS) ? table_seed(i) : 8'h00;
            end
            for (int j = 0; j < TF_DEPTH; j++) begin
                tf_mem[j] <= (j == TF_DEPTH - 1) ? STATUS_AT_RESET : 8'h00;
            end
            data_hi <= 8'h00;
            ctl_q   <= 8'h00;
            bus8    <= 1'b0;
        end else if (commit) begin
            unique case (c_region)
                RGN_ATTR: begin
                    if (c_lo && !c_lo_addr[0] && int'(c_lo_addr) >= CIS_BYTES) begin
                        attr_mem[c_lo_addr[ADDR_W-1:1]] <= c_data[7:0];
                    end
                end
                RGN_TASK: begin
                    if (c_lo) begin
                        tf_mem[c_lo_off] <= c_data[7:0];
                        if (c_lo_off == OFF_CMD && c_data[7:0] == CMD_SET_FEATURE) begin
                            if (tf_mem[OFF_FEAT] == FEAT_BUS8_ON) begin
                                bus8 <= 1'b1;
                            end else if (tf_mem[OFF_FEAT] == FEAT_BUS8_OFF) begin
                                bus8 <= 1'b0;
                            end
                        end
                    end
                    if (c_hi) begin
                        if (c_hi_off == OFF_FEAT) begin
                            data_hi <= c_data[15:8];
                        end else begin
                            tf_mem[c_hi_off] <= c_data[15:8];
                        end
                    end
                end
                RGN_ALT: begin
                    ctl_q <= c_data[7:0];
                end
                default: ;
            endcase
        end
    end

    // Low-lane read mux
    always_comb begin
        rd_lo = 8'h00;
        if (lo_act) begin
            unique case (region)
                RGN_ATTR: rd_lo = lo_addr[0] ? INVALID_BYTE : attr_mem[lo_addr[ADDR_W-1:1]];
                RGN_TASK: rd_lo = tf_mem[lo_addr[TF_AW-1:0]];
                RGN_ALT:  rd_lo = tf_mem[OFF_CMD];
                default:  rd_lo = 8'h00;
            endcase
        end
    end

    // High-lane read mux
    always_comb begin
        rd_hi = 8'h00;
        if (hi_act) begin
            unique case (region)
                RGN_ATTR: rd_hi = INVALID_BYTE;
                RGN_TASK: rd_hi = (hi_addr[TF_AW-1:0] == OFF_FEAT) ? data_hi
                                                                   : tf_mem[hi_addr[TF_AW-1:0]];
                default:  rd_hi = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/pcc_lane_decoder.sv
// Top of the byte-lane access decoder: strap latch, cycle decoder and the
// register array, with per-lane drive enables toward the host pins.
// Assumes: pad logic tri-states each lane whose enable is low.
module pcc_lane_decoder
    import pcc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int TF_AW     = 3,
    parameter int CIS_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              lo_oe,
    output logic              hi_oe,
    output logic              ide_mode,
    output logic [7:0]        ctl_q
);

    region_e           region;
    logic              rd_act;
    logic              wr_act;
    logic              lo_act;
    logic              hi_act;
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic [7:0]        rd_lo;
    logic [7:0]        rd_hi;
    logic              bus8;

    pcc_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (oe_n),
        .ide_mode (ide_mode)
    );

    pcc_access_decode #(
        .ADDR_W (ADDR_W),
        .TF_AW  (TF_AW)
    ) u_dec (
        .ide_mode (ide_mode),
        .bus8     (bus8),
        .reg_n    (reg_n),
        .ce1_n    (ce1_n),
        .ce2_n    (ce2_n),
        .addr     (addr),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .iord_n   (iord_n),
        .iowr_n   (iowr_n),
        .region   (region),
        .rd_act   (rd_act),
        .wr_act   (wr_act),
        .lo_act   (lo_act),
        .hi_act   (hi_act),
        .lo_addr  (lo_addr),
        .hi_addr  (hi_addr)
    );

    pcc_regfile #(
        .ADDR_W    (ADDR_W),
        .TF_AW     (TF_AW),
        .CIS_BYTES (CIS_BYTES)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .region  (region),
        .wr_act  (wr_act),
        .lo_act  (lo_act),
        .hi_act  (hi_act),
        .lo_addr (lo_addr),
        .hi_addr (hi_addr),
        .wdata   (wdata),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi),
        .bus8    (bus8),
        .ctl_q   (ctl_q)
    );

    // Lane drive enables and gated read data
    always_comb begin
        lo_oe = rd_act && lo_act;
        hi_oe = rd_act && hi_act;
        rdata = {hi_oe ? rd_hi : 8'h00, lo_oe ? rd_lo : 8'h00};
    end

endmodule

// File: rtl/pcc_lane_checker.sv
// Cycle-by-cycle properties of the byte-lane decoder, bound to its top.
module pcc_lane_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_n,
    input logic              ce1_n,
    input logic              ce2_n,
    input logic [ADDR_W-1:0] addr,
    input logic              oe_n,
    input logic              iord_n,
    input logic              iowr_n,
    input logic [15:0]       rdata,
    input logic              lo_oe,
    input logic              hi_oe,
    input logic              ide_mode,
    input logic [7:0]        ctl_q
);

    // R1
    standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && ce2_n) |-> (!lo_oe && !hi_oe));

    // R2
    byte_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_mode && !ce1_n && ce2_n) |-> !hi_oe);

    // R4
    odd_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_mode && ce1_n && !ce2_n) |-> !lo_oe);

    // R5
    attr_hi_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_mode && !reg_n && !oe_n && hi_oe) |-> (rdata[15:8] == 8'hFF));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(ide_mode));

    // R8
    ide_iord_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_mode && iord_n) |-> (!lo_oe && !hi_oe));

    // R8
    ide_both_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_mode && !ce1_n && !ce2_n) |-> (!lo_oe && !hi_oe));

    // R10
    alt_lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_mode && ce1_n && !ce2_n) |-> !hi_oe);

    // R11
    ctl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q) |-> ($past(iowr_n) && !$past(iowr_n, 2)));

    // R2
    addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_oe |-> !$isunknown(addr));

endmodule

bind pcc_lane_decoder pcc_lane_checker #(.ADDR_W(ADDR_W)) u_lane_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_n    (reg_n),
    .ce1_n    (ce1_n),
    .ce2_n    (ce2_n),
    .addr     (addr),
    .oe_n     (oe_n),
    .iord_n   (iord_n),
    .iowr_n   (iowr_n),
    .rdata    (rdata),
    .lo_oe    (lo_oe),
    .hi_oe    (hi_oe),
    .ide_mode (ide_mode),
    .ctl_q    (ctl_q)
);

// File: tb/tb_pcc_lane_decoder.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected lane state, a monitor
// compares on the falling clock edge.
module tb_pcc_lane_decoder;

    typedef struct {
        logic        lo;
        logic        hi;
        logic [15:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_n = 1'b1;
    logic        ce1_n = 1'b1;
    logic        ce2_n = 1'b1;
    logic [7:0]  addr = 8'h00;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic        iord_n = 1'b1;
    logic        iowr_n = 1'b1;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        lo_oe;
    logic        hi_oe;
    logic        ide_mode;
    logic [7:0]  ctl_q;

    int   n_checks = 0;
    int   n_errors = 0;
    logic ide_run = 1'b0;
    logic finished = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    pcc_lane_decoder dut (
        .clk(clk), .rst_n(rst_n), .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .addr(addr), .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .wdata(wdata), .rdata(rdata), .lo_oe(lo_oe), .hi_oe(hi_oe),
        .ide_mode(ide_mode), .ctl_q(ctl_q)
    );

    function automatic logic [7:0] rom_byte(input int i);
        return 8'((i * 37 + 5) % 256);
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        reg_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1;
        oe_n = ide_run ? 1'b0 : 1'b1;
        we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1;
    endtask

    task automatic do_reset(input logic ide);
        ide_run = ide;
        rst_n = 1'b0;
        idle();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic lo, input logic hi, input logic [15:0] d, input string tag);
        exp_t e;
        e.lo = lo; e.hi = hi; e.data = d; e.tag = tag;
        sb.push_back(e);
    endtask

    // One read cycle; use_io picks the I/O strobe, else the output enable
    task automatic rd_acc(input logic rg, input logic c1, input logic c2, input logic [7:0] a,
                          input logic use_io, input logic lo, input logic hi,
                          input logic [15:0] d, input string tag);
        @(posedge clk);
        #1;
        reg_n = rg; ce1_n = c1; ce2_n = c2; addr = a;
        if (use_io) iord_n = 1'b0; else oe_n = 1'b0;
        push(lo, hi, d, tag);
        @(posedge clk);
        #1 idle();
    endtask

    // One write cycle held low for two clocks, then released
    task automatic wr_acc(input logic rg, input logic c1, input logic c2, input logic [7:0] a,
                          input logic use_io, input logic [15:0] d);
        @(posedge clk);
        #1;
        reg_n = rg; ce1_n = c1; ce2_n = c2; addr = a; wdata = d;
        if (use_io) iowr_n = 1'b0; else we_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 idle();
        @(posedge clk);
        #1;
    endtask

    // Monitor: pop and compare one expected item per falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [15:0] mask;
            e = sb.pop_front();
            mask = {{8{e.hi}}, {8{e.lo}}};
            n_checks++;
            if (lo_oe !== e.lo || hi_oe !== e.hi || (rdata & mask) !== (e.data & mask)) begin
                n_errors++;
                $display("FAIL %s: actual lo=%b hi=%b data=%h expected lo=%b hi=%b data=%h",
                         e.tag, lo_oe, hi_oe, rdata, e.lo, e.hi, e.data);
            end
        end
    end

    initial begin
        // ---------------- card personality ----------------
        do_reset(1'b0);
        chk({15'd0, ide_mode}, 16'd0, "R12 mode after reset");
        rd_acc(1, 0, 1, 8'h07, 0, 1, 0, 16'h0050, "R12 status reset");
        rd_acc(1, 0, 1, 8'h04, 0, 1, 0, 16'h0000, "R12 task reg zero");
        rd_acc(1, 1, 1, 8'h07, 0, 0, 0, 16'h0000, "R1 standby read");
        rd_acc(0, 0, 1, 8'h04, 0, 1, 0, {8'h00, rom_byte(2)}, "R5 attr even byte");
        rd_acc(0, 0, 1, 8'h05, 0, 1, 0, 16'h00FF, "R5 attr odd byte");
        rd_acc(0, 0, 0, 8'h04, 0, 1, 1, {8'hFF, rom_byte(2)}, "R5 attr word");
        wr_acc(0, 0, 1, 8'h04, 0, 16'h0033);
        rd_acc(0, 0, 1, 8'h04, 0, 1, 0, {8'h00, rom_byte(2)}, "R6 table protected");
        rd_acc(0, 0, 1, 8'h7E, 0, 1, 0, {8'h00, rom_byte(63)}, "R6 table top entry");
        wr_acc(0, 0, 1, 8'h80, 0, 16'h00A5);
        rd_acc(0, 0, 1, 8'h80, 0, 1, 0, 16'h00A5, "R6 writable attr");
        wr_acc(0, 0, 1, 8'h81, 0, 16'h003C);
        rd_acc(0, 0, 0, 8'h80, 0, 1, 1, 16'hFFA5, "R5 odd attr write dropped");
        wr_acc(0, 0, 1, 8'h02, 1, 16'h0012);
        wr_acc(0, 0, 1, 8'h03, 1, 16'h0034);
        rd_acc(0, 0, 0, 8'h02, 1, 1, 1, 16'h3412, "R3 R7 io word read");
        rd_acc(1, 1, 0, 8'h02, 0, 0, 1, 16'h3400, "R4 odd-only read");
        rd_acc(1, 0, 1, 8'h03, 0, 1, 0, 16'h0034, "R2 odd byte on low lane");
        rd_acc(1, 0, 1, 8'h02, 0, 1, 0, 16'h0012, "R2 even byte on low lane");
        wr_acc(1, 0, 0, 8'h00, 0, 16'hBEEF);
        rd_acc(0, 0, 0, 8'h00, 1, 1, 1, 16'hBEEF, "R3 R7 word through data pair");
        rd_acc(1, 0, 1, 8'h01, 0, 1, 0, 16'h0000, "R7 offset 1 separate");
        rd_acc(1, 1, 0, 8'h00, 0, 0, 1, 16'hBE00, "R4 R7 data high byte");
        wr_acc(1, 1, 1, 8'h04, 0, 16'h0077);
        rd_acc(1, 0, 1, 8'h04, 0, 1, 0, 16'h0000, "R1 standby write ignored");
        // R11: old value until the edge that sees the strobe released
        @(posedge clk);
        #1;
        reg_n = 1'b1; ce1_n = 1'b0; ce2_n = 1'b1; addr = 8'h05; wdata = 16'h005A; we_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 we_n = 1'b1; oe_n = 1'b0;
        push(1, 0, 16'h0000, "R11 before commit edge");
        @(posedge clk);
        #1 push(1, 0, 16'h005A, "R11 after commit edge");
        @(posedge clk);
        #1 idle();

        // ---------------- disk personality ----------------
        do_reset(1'b1);
        chk({15'd0, ide_mode}, 16'd1, "R8 strap latched");
        rd_acc(0, 0, 1, 8'h07, 0, 0, 0, 16'h0000, "R8 output enable ignored");
        wr_acc(1, 0, 1, 8'h02, 0, 16'h0099);
        rd_acc(0, 0, 1, 8'h02, 1, 1, 0, 16'h0000, "R8 memory write ignored");
        rd_acc(1, 0, 1, 8'h07, 1, 1, 0, 16'h0050, "R8 register select ignored");
        rd_acc(0, 0, 0, 8'h00, 1, 0, 0, 16'h0000, "R8 both enables invalid");
        wr_acc(0, 0, 1, 8'h00, 1, 16'h1234);
        rd_acc(0, 0, 1, 8'h00, 1, 1, 1, 16'h1234, "R9 16-bit data default");
        wr_acc(0, 0, 1, 8'h01, 1, 16'h0001);
        wr_acc(0, 0, 1, 8'h07, 1, 16'h00EF);
        rd_acc(0, 0, 1, 8'h00, 1, 1, 0, 16'h0034, "R9 narrowed to 8-bit");
        wr_acc(0, 0, 1, 8'h00, 1, 16'hAA56);
        rd_acc(0, 0, 1, 8'h00, 1, 1, 0, 16'h0056, "R9 8-bit write low only");
        wr_acc(0, 0, 1, 8'h01, 1, 16'h0081);
        wr_acc(0, 0, 1, 8'h07, 1, 16'h00EF);
        rd_acc(0, 0, 1, 8'h00, 1, 1, 1, 16'h1256, "R9 restored to 16-bit");
        rd_acc(0, 1, 0, 8'h06, 1, 1, 0, 16'h00EF, "R10 alternate status");
        wr_acc(0, 1, 0, 8'h06, 1, 16'h0006);
        chk({8'h00, ctl_q}, 16'h0006, "R10 device control");
        rd_acc(0, 0, 1, 8'h06, 1, 1, 0, 16'h0000, "R10 task reg 6 untouched");
        rd_acc(0, 1, 0, 8'h05, 1, 0, 0, 16'h0000, "R8 secondary window other offset");

        wait (sb.size() == 0);
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule